// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Engine

This block moves data on behalf of peripherals without the CPU. It has two channels, and each one holds a source pointer and a destination pointer inside a 20-bit (1 MB) byte address space. It also holds a transfer counter with a reload value and a small set of mode bits. Each accepted request steals exactly one bus cycle pair: a read from the source address followed by a write of the same data to the destination address. One unit of 8 or 16 bits moves per request.

Requests for a channel come from three places:
- a peripheral pulse;
- a selectable edge (falling only, or both) of an external pin;
- a software trigger, which is always active.

No interrupt mask gates any of them. Channel 0 always wins when both channels wait. Every counter underflow raises a one-cycle interrupt pulse for that channel. After the underflow, single mode switches the channel off, and repeat mode reloads the counter and keeps going.

Configuration values are presented as plain per-channel inputs. The enable bit is set and cleared through strobes, and its live value is visible on an output, so software can see that a single-mode run has ended.

Top module: `dma2_engine`

## Requirements
- R1: When both channels hold a pending request while the engine is idle, channel 0 is served first, and channel 1 follows in the next transfer slot.
- R2: `cfg_wide`=1 moves 16 bits per transfer and steps an incrementing pointer by 2. `cfg_wide`=0 moves the low byte, writes zero in bits 15:8, and steps by 1. `bus_wide` shows the size of the current cycle.
- R3: A fixed pointer always uses its programmed base. When both `cfg_src_inc` and `cfg_dst_inc` are 1, the destination is treated as fixed and only the source increments.
- R4: A request is accepted only while the channel's enable bit is 1. Requests seen while it is 0 are discarded and never start a later transfer. One accepted request causes exactly one transfer.
- R5: On the first transfer after `en_set`, the incrementing pointer starts from its programmed base and the counter starts from `cfg_reload`, whatever state an earlier run left behind.
- R6: In single mode (`cfg_repeat`=0), a reload value N gives N+1 transfers. The transfer that underflows the counter clears the enable bit.
- R7: In repeat mode, the counter reloads from `cfg_reload` on each underflow. The enable bit stays 1 until `en_clr`, and the incrementing pointer keeps advancing across underflows.
- R8: `irq` pulses high for exactly one cycle for each counter underflow, in the cycle after the write that caused it.
- R9: `cfg_sel` encoding: 0 = peripheral pulse `periph_req`, 1 = falling edge of `ext_pin`, 2 = both edges of `ext_pin`. `sw_trig` requests a transfer under every setting, and a source that is not selected has no effect.
- R10: A request that arrives while its channel already has a pending or in-flight request sets a single pending flag. Any further requests in that window merge into it and are not counted.
- R11: Each transfer is one cycle with `bus_rd` high at the source address, then the next cycle with `bus_wr` high at the destination address. The write carries the data returned on `bus_rdata` during the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src_base | input | 2x20 | Source base address per channel |
| cfg_dst_base | input | 2x20 | Destination base address per channel |
| cfg_reload | input | 2x16 | Counter reload value per channel |
| cfg_wide | input | 2 | 1 = 16-bit unit, 0 = 8-bit unit |
| cfg_src_inc | input | 2 | Source pointer increments when 1 |
| cfg_dst_inc | input | 2 | Destination pointer increments when 1 |
| cfg_repeat | input | 2 | 1 = repeat mode, 0 = single mode |
| cfg_sel | input | 2x2 | Hardware request source select |
| en_set | input | 2 | Strobe: set enable, arm first-transfer reload |
| en_clr | input | 2 | Strobe: clear enable |
| periph_req | input | 2 | Peripheral request pulses |
| ext_pin | input | 2 | External request pin per channel |
| sw_trig | input | 2 | Software trigger strobes |
| en_state | output | 2 | Current enable bit per channel |
| irq | output | 2 | Underflow interrupt pulse per channel |
| bus_addr | output | 20 | Byte address of current bus cycle |
| bus_rd | output | 1 | Read cycle |
| bus_wr | output | 1 | Write cycle |
| bus_wide | output | 1 | Cycle is 16 bits wide |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid in the read cycle |

## Verification
The bench checks the exact length of a single-mode run: a counter that stops one transfer early or late would leave the enable bit set, or write one byte too many. It re-enables a channel that was stopped half way, so a design that resumed from the old pointer or count would read the wrong address and raise its interrupt at the wrong moment. Back-to-back triggers and triggers sent while disabled check that pending requests neither pile up nor survive a disable. Runs with both pointers set to increment, and with both pin edge modes, catch a destination that walks away from its base and an edge detector that fires on the wrong transition.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_st_t;

  localparam logic [1:0] SRC_PERIPH   = 2'd0;
  localparam logic [1:0] SRC_PIN_FALL = 2'd1;
  localparam logic [1:0] SRC_PIN_BOTH = 2'd2;
endpackage

// File: rtl/dma2_req_src.sv
module dma2_req_src
  import dma2_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       pin,
  input  logic       periph,
  input  logic       sw,
  output logic       req
);
  logic pin_q;
  logic fall, rise, hw;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= pin;
    else     pin_q <= pin;
  end

  assign fall = pin_q & ~pin;
  assign rise = ~pin_q & pin;

  always_comb begin
    case (sel)
      SRC_PERIPH:   hw = periph;
      SRC_PIN_FALL: hw = fall;
      SRC_PIN_BOTH: hw = fall | rise;
      default:      hw = 1'b0;
    endcase
  end

  assign req = hw | sw;
endmodule

// File: rtl/dma2_chan.sv
module dma2_chan #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_src,
  input  logic [ADDR_W-1:0] base_dst,
  input  logic [CNT_W-1:0]  reload,
  input  logic              wide,
  input  logic              src_inc,
  input  logic              dst_inc,
  input  logic              repeat_mode,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              req,
  input  logic              grant,
  input  logic              done,
  output logic              en_q,
  output logic              pend_q,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              irq
);
  logic              en_r, fresh_r, pend_r, irq_r, en_n;
  logic [ADDR_W-1:0] ptr_r, inc_base, inc_cur, step;
  logic [CNT_W-1:0]  cnt_r, cnt_eff;
  logic              dst_inc_eff, underflow;

  assign dst_inc_eff = dst_inc & ~src_inc;
  assign cnt_eff     = fresh_r ? reload : cnt_r;
  assign underflow   = (cnt_eff == '0);
  assign inc_base    = src_inc ? base_src : base_dst;
  assign inc_cur     = fresh_r ? inc_base : ptr_r;
  assign src_addr    = src_inc ? inc_cur : base_src;
  assign dst_addr    = dst_inc_eff ? inc_cur : base_dst;
  assign step        = wide ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    en_n = en_r;
    if (done && underflow && !repeat_mode) en_n = 1'b0;
    if (en_clr) en_n = 1'b0;
    if (en_set) en_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r    <= 1'b0;
      fresh_r <= 1'b0;
      pend_r  <= 1'b0;
      irq_r   <= 1'b0;
      ptr_r   <= '0;
      cnt_r   <= '0;
    end else begin
      irq_r  <= done & underflow;
      en_r   <= en_n;
      pend_r <= en_n & ((pend_r & ~grant) | req);
      if (done) begin
        ptr_r   <= inc_cur + step;
        fresh_r <= 1'b0;
        if (underflow) cnt_r <= repeat_mode ? reload : '0;
        else           cnt_r <= cnt_eff - 1'b1;
      end
      if (en_set) fresh_r <= 1'b1;
    end
  end

  assign en_q   = en_r;
  assign pend_q = pend_r;
  assign irq    = irq_r;

  // R8: interrupt is a single-cycle pulse
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq_r |=> !irq_r);
  // R6: single-mode underflow switches the channel off
  p_single_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (done && underflow && !repeat_mode && !en_set) |=> !en_r);
  // R7: repeat-mode underflow keeps the channel on
  p_repeat_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (done && underflow && repeat_mode && en_r && !en_clr) |=> en_r);
  // R10: a pending request never outlives the enable bit
  p_pend_gated_r10: assert property (@(posedge clk) disable iff (rst)
    pend_r |-> en_r);
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
  import dma2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NCH-1:0][ADDR_W-1:0]  cfg_src_base,
  input  logic [NCH-1:0][ADDR_W-1:0]  cfg_dst_base,
  input  logic [NCH-1:0][CNT_W-1:0]   cfg_reload,
  input  logic [NCH-1:0]              cfg_wide,
  input  logic [NCH-1:0]              cfg_src_inc,
  input  logic [NCH-1:0]              cfg_dst_inc,
  input  logic [NCH-1:0]              cfg_repeat,
  input  logic [NCH-1:0][1:0]         cfg_sel,
  input  logic [NCH-1:0]              en_set,
  input  logic [NCH-1:0]              en_clr,
  input  logic [NCH-1:0]              periph_req,
  input  logic [NCH-1:0]              ext_pin,
  input  logic [NCH-1:0]              sw_trig,
  output logic [NCH-1:0]              en_state,
  output logic [NCH-1:0]              irq,
  output logic [ADDR_W-1:0]           bus_addr,
  output logic                        bus_rd,
  output logic                        bus_wr,
  output logic                        bus_wide,
  output logic [DATA_W-1:0]           bus_wdata,
  input  logic [DATA_W-1:0]           bus_rdata
);
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int BYTE_W = DATA_W / 2;

  xfer_st_t                 state;
  logic [CH_W-1:0]          cur_ch, pick;
  logic                     any_pend;
  logic [NCH-1:0]           req, pend, grant, done;
  logic [NCH-1:0][ADDR_W-1:0] src_addr, dst_addr;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma2_req_src u_src (
      .clk(clk), .rst(rst), .sel(cfg_sel[g]), .pin(ext_pin[g]),
      .periph(periph_req[g]), .sw(sw_trig[g]), .req(req[g])
    );
    assign grant[g] = (state == ST_IDLE) && any_pend && (pick == CH_W'(g));
    assign done[g]  = (state == ST_WR) && (cur_ch == CH_W'(g));
    dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst),
      .base_src(cfg_src_base[g]), .base_dst(cfg_dst_base[g]),
      .reload(cfg_reload[g]), .wide(cfg_wide[g]),
      .src_inc(cfg_src_inc[g]), .dst_inc(cfg_dst_inc[g]),
      .repeat_mode(cfg_repeat[g]),
      .en_set(en_set[g]), .en_clr(en_clr[g]), .req(req[g]),
      .grant(grant[g]), .done(done[g]),
      .en_q(en_state[g]), .pend_q(pend[g]),
      .src_addr(src_addr[g]), .dst_addr(dst_addr[g]), .irq(irq[g])
    );
  end

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick = CH_W'(i);
    end
  end
  assign any_pend = |pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_ch    <= '0;
      bus_addr  <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wide  <= 1'b0;
      bus_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (any_pend) begin
          state    <= ST_RD;
          cur_ch   <= pick;
          bus_rd   <= 1'b1;
          bus_addr <= src_addr[pick];
          bus_wide <= cfg_wide[pick];
        end
        ST_RD: begin
          state     <= ST_WR;
          bus_rd    <= 1'b0;
          bus_wr    <= 1'b1;
          bus_addr  <= dst_addr[cur_ch];
          bus_wdata <= bus_wide ? bus_rdata
                                : {{(DATA_W-BYTE_W){1'b0}}, bus_rdata[BYTE_W-1:0]};
        end
        default: begin
          state  <= ST_IDLE;
          bus_wr <= 1'b0;
        end
      endcase
    end
  end

  // R11: every read cycle is followed by its write cycle
  p_wr_after_rd_r11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_wr);
  // R11: a wide write carries the word read in the cycle before
  p_wdata_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wide) |=> (bus_wdata == $past(bus_rdata)));
  // R1: channel 0 pending at an idle slot is the one served
  p_prio_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && pend[0]) |=> (bus_rd && cur_ch == '0));
  // R3: with both increment bits set, the write goes to the destination base
  p_fixed_dst_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && cfg_src_inc[cur_ch] && cfg_dst_inc[cur_ch])
      |-> (bus_addr == cfg_dst_base[cur_ch]));
endmodule

// File: tb/dma2_engine_tb.sv
module dma2_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int AW  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0][AW-1:0] cfg_src_base = '0, cfg_dst_base = '0;
  logic [NCH-1:0][15:0]   cfg_reload = '0;
  logic [NCH-1:0] cfg_wide = '0, cfg_src_inc = '0, cfg_dst_inc = '0, cfg_repeat = '0;
  logic [NCH-1:0][1:0] cfg_sel = '0;
  logic [NCH-1:0] en_set = '0, en_clr = '0, periph_req = '0, sw_trig = '0;
  logic [NCH-1:0] ext_pin = '1;
  logic [NCH-1:0] en_state, irq;
  logic [AW-1:0]  bus_addr;
  logic bus_rd, bus_wr, bus_wide;
  logic [15:0] bus_wdata, bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2_engine u_dut (
    .clk(clk), .rst(rst), .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_reload(cfg_reload), .cfg_wide(cfg_wide), .cfg_src_inc(cfg_src_inc),
    .cfg_dst_inc(cfg_dst_inc), .cfg_repeat(cfg_repeat), .cfg_sel(cfg_sel),
    .en_set(en_set), .en_clr(en_clr), .periph_req(periph_req), .ext_pin(ext_pin),
    .sw_trig(sw_trig), .en_state(en_state), .irq(irq), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  // byte memory model, 1 KB window
  logic [7:0] mem [1024];
  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction
  initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);
  assign bus_rdata = bus_wide ? {mem[bus_addr[9:0] + 10'd1], mem[bus_addr[9:0]]}
                              : {8'h00, mem[bus_addr[9:0]]};

  int wr_cnt = 0, rd_cnt = 0, seq_err = 0, irq_err = 0;
  int irq_cnt [NCH];
  logic [AW-1:0] rd_log [64];
  logic [AW-1:0] last_wr;
  logic prev_rd = 1'b0;
  logic [NCH-1:0] prev_irq = '0;
  initial for (int c = 0; c < NCH; c++) irq_cnt[c] = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_wr) begin
        wr_cnt++;
        last_wr = bus_addr;
        mem[bus_addr[9:0]] = bus_wdata[7:0];
        if (bus_wide) mem[bus_addr[9:0] + 10'd1] = bus_wdata[15:8];
        if (!prev_rd) seq_err++;
      end
      if (bus_rd) begin
        rd_log[rd_cnt % 64] = bus_addr;
        rd_cnt++;
      end
      for (int c = 0; c < NCH; c++) begin
        if (irq[c]) irq_cnt[c]++;
        if (irq[c] && prev_irq[c]) irq_err++;
      end
      prev_irq = irq;
      prev_rd  = bus_rd;
    end
  end

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic chk_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic trig(input int ch);
    @(negedge clk) sw_trig[ch] = 1'b1;
    @(negedge clk) sw_trig[ch] = 1'b0;
    cycles(6);
  endtask
  task automatic enable(input int ch);
    @(negedge clk) en_set[ch] = 1'b1;
    @(negedge clk) en_set[ch] = 1'b0;
  endtask
  task automatic disable_ch(input int ch);
    @(negedge clk) en_clr[ch] = 1'b1;
    @(negedge clk) en_clr[ch] = 1'b0;
  endtask
  task automatic setup(input int ch, input int s, input int d, input int rl,
                       input bit w, input bit si, input bit di, input bit rp, input int sel);
    cfg_src_base[ch] = AW'(s); cfg_dst_base[ch] = AW'(d); cfg_reload[ch] = 16'(rl);
    cfg_wide[ch] = w; cfg_src_inc[ch] = si; cfg_dst_inc[ch] = di;
    cfg_repeat[ch] = rp; cfg_sel[ch] = 2'(sel);
  endtask

  task automatic t_reset();
    chk_eq("R4 reset en_state", int'(en_state), 0);
    chk_eq("R8 reset irq", int'(irq), 0);
    chk_eq("R11 reset bus idle", int'({bus_rd, bus_wr}), 0);
  endtask

  task automatic t_single();
    int w0 = wr_cnt, i0 = irq_cnt[0];
    setup(0, 'h100, 'h200, 2, 0, 1, 0, 0, 0);
    enable(0);
    for (int k = 0; k < 4; k++) trig(0);
    chk_eq("R6 single run length", wr_cnt - w0, 3);
    chk_eq("R6 enable cleared", int'(en_state[0]), 0);
    chk_eq("R8 one irq on underflow", irq_cnt[0] - i0, 1);
    chk_eq("R2 byte step last read", int'(rd_log[(rd_cnt-1)%64]), 'h102);
    chk_eq("R3 fixed dst data", int'(mem['h200]), int'(pat('h102)));
  endtask

  task automatic t_wide();
    int i1 = irq_cnt[1];
    setup(1, 'h300, 'h340, 1, 1, 0, 1, 0, 0);
    enable(1);
    trig(1); trig(1);
    chk_eq("R2 wide word 0", int'({mem['h341], mem['h340]}), int'({pat('h301), pat('h300)}));
    chk_eq("R2 wide word 1", int'({mem['h343], mem['h342]}), int'({pat('h301), pat('h300)}));
    chk_eq("R2 untouched beyond", int'(mem['h344]), int'(pat('h344)));
    chk_eq("R2 last write step 2", int'(last_wr), 'h342);
    chk_eq("R6 wide single irq", irq_cnt[1] - i1, 1);
  endtask

  task automatic t_repeat();
    int i0 = irq_cnt[0], w0;
    setup(0, 'h110, 'h210, 1, 0, 1, 0, 1, 0);
    enable(0);
    for (int k = 0; k < 5; k++) trig(0);
    chk_eq("R7 repeat irq count", irq_cnt[0] - i0, 2);
    chk_eq("R7 repeat stays enabled", int'(en_state[0]), 1);
    chk_eq("R7 pointer keeps advancing", int'(rd_log[(rd_cnt-1)%64]), 'h114);
    disable_ch(0);
    w0 = wr_cnt;
    trig(0);
    chk_eq("R4 trigger after clear ignored", wr_cnt - w0, 0);
  endtask

  task automatic t_reenable();
    int i1;
    setup(1, 'h120, 'h220, 5, 0, 1, 0, 0, 0);
    enable(1);
    trig(1); trig(1);
    disable_ch(1);
    enable(1);
    i1 = irq_cnt[1];
    trig(1);
    chk_eq("R5 pointer restarts at base", int'(rd_log[(rd_cnt-1)%64]), 'h120);
    for (int k = 0; k < 4; k++) trig(1);
    chk_eq("R5 no early underflow", irq_cnt[1] - i1, 0);
    trig(1);
    chk_eq("R5 counter reloaded full", irq_cnt[1] - i1, 1);
  endtask

  task automatic t_prio();
    int r0;
    setup(0, 'h130, 'h230, 100, 0, 0, 0, 0, 0);
    setup(1, 'h140, 'h240, 100, 0, 0, 0, 0, 0);
    enable(0); enable(1);
    r0 = rd_cnt;
    @(negedge clk) sw_trig = 2'b11;
    @(negedge clk) sw_trig = 2'b00;
    cycles(10);
    chk_eq("R1 channel 0 first", int'(rd_log[r0%64]), 'h130);
    chk_eq("R1 channel 1 second", int'(rd_log[(r0+1)%64]), 'h140);
  endtask

  task automatic t_pending();
    int w0 = wr_cnt;
    @(negedge clk) sw_trig[0] = 1'b1;
    cycles(3);
    sw_trig[0] = 1'b0;
    cycles(12);
    chk_eq("R10 burst merges", wr_cnt - w0, 2);
  endtask

  task automatic t_pin();
    int w0;
    setup(1, 'h150, 'h250, 100, 0, 0, 0, 0, 1);
    w0 = wr_cnt;
    @(negedge clk) ext_pin[1] = 1'b0; cycles(8);
    @(negedge clk) ext_pin[1] = 1'b1; cycles(8);
    chk_eq("R9 falling edge only", wr_cnt - w0, 1);
    cfg_sel[1] = 2'd2;
    w0 = wr_cnt;
    @(negedge clk) ext_pin[1] = 1'b0; cycles(8);
    @(negedge clk) ext_pin[1] = 1'b1; cycles(8);
    chk_eq("R9 both edges", wr_cnt - w0, 2);
    w0 = wr_cnt;
    @(negedge clk) periph_req[1] = 1'b1;
    @(negedge clk) periph_req[1] = 1'b0; cycles(8);
    chk_eq("R9 unselected periph ignored", wr_cnt - w0, 0);
    cfg_sel[1] = 2'd0;
    @(negedge clk) periph_req[1] = 1'b1;
    @(negedge clk) periph_req[1] = 1'b0; cycles(8);
    chk_eq("R9 periph selected", wr_cnt - w0, 1);
  endtask

  task automatic t_both_inc();
    setup(0, 'h160, 'h260, 100, 0, 1, 1, 0, 0);
    enable(0);
    trig(0);
    trig(0);
    chk_eq("R3 dst held at base", int'(last_wr), 'h260);
    chk_eq("R3 src still steps", int'(rd_log[(rd_cnt-1)%64]), 'h161);
    chk_eq("R3 dst+1 untouched", int'(mem['h261]), int'(pat('h261)));
  endtask

  task automatic t_disabled();
    int w0;
    disable_ch(1);
    w0 = wr_cnt;
    trig(1);
    enable(1);
    cycles(10);
    chk_eq("R4 request while disabled dropped", wr_cnt - w0, 0);
    trig(1);
    chk_eq("R4 one request one transfer", wr_cnt - w0, 1);
  endtask

  bit finished = 0;
  task automatic summary();
    if (!finished) begin
      finished = 1;
      chk_eq("R11 write follows read", seq_err, 0);
      chk_eq("R8 irq pulse width", irq_err, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_wide();
    t_repeat();
    t_reenable();
    t_prio();
    t_pending();
    t_pin();
    t_both_inc();
    t_disabled();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    summary();
  end
endmodule